// File: doc/BRIEF.md
# Carry-Save Multi-Operand Multiply-Accumulator

This block is a purely combinational datapath that forms one W-bit result from a fixed set of terms. Each term is either a plain addend taken from its A field or the product of its A and B fields. Elaboration parameters decide, for each term, whether it is signed or unsigned and whether it is added or subtracted. A small vector of loose single-bit inputs is added at weight one. The result wraps modulo 2^W.

All terms are turned into W-bit partial-product rows, with one row per multiplier bit. A single tree of 3:2 compressors reduces every row at once, and one ordinary two-input adder finishes the sum. Subtraction costs no separate subtractor. Every row of a subtracted term is inverted, and the matching +1 corrections are gathered into one constant row. The loose bits ride in the free bit 0 of each shifted carry row, so they normally cost no extra rows. If any input is unknown in a four-state simulation, the whole result is driven unknown.

Top module: `csa_macc`

## Requirements
- R1: `result` equals the sum of all terms plus the loose bits, reduced modulo 2^W, for any input values. Term t occupies `opA[t*AW +: AW]` and `opB[t*BW +: BW]`.
- R2: A term whose bit in `SIGNED_MASK` is 1 has its operands sign-extended to W bits. A term whose bit is 0 has its operands zero-extended. The most negative values and all-ones fields show the difference.
- R3: A term whose bit in `PROD_MASK` is 1 contributes the product of its A and B fields. This includes the product of two most-negative signed operands.
- R4: A term whose bit in `SUB_MASK` is 1 has its value subtracted from the total, not added. Subtracting a zero term leaves the total unchanged.
- R5: For a term whose `PROD_MASK` bit is 0, its B field has no effect on `result`.
- R6: Each bit of `carryBits` that is 1 adds exactly 1 to the total. With every bit set, the total rises by NCIN.
- R7: When every input is zero, `result` is zero, whatever the subtract settings are.
- R8: Any part of the true sum of weight 2^W or more is discarded. A negative total therefore appears as its two's-complement code, for example 2^W - 16065 for -16065.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | NTERM*AW | Packed A fields, term t at bits t*AW upward |
| opB | input | NTERM*BW | Packed B fields, term t at bits t*BW upward; ignored for addend terms |
| carryBits | input | NCIN | Loose bits, each of weight one |
| result | output | W | Wrapped sum of all terms and loose bits |

## Verification
The bench tries the datapath with four groups of input patterns, and each group separates a different fault. Lone signed and unsigned terms at their extreme codes separate sign extension from zero extension and expose a wrong sign row. Patterns with only subtracted terms, or only loose bits, isolate the inverted rows and the +1 correction path. A pair of vectors that differ only in an addend's B field shows whether that field leaks into the sum. Random operands, run on two elaborations with opposite subtract settings, cover the carry interactions across the full compressor tree.

// File: rtl/csa_macc_pkg.sv
package csa_macc_pkg;

  typedef struct packed {
    logic negate;
    logic signedOp;
  } termCtlT;

  function automatic int rowsOfTerm(bit prod, bit sgn, int mw);
    if (!prod) return 1;
    return sgn ? mw + 1 : mw;
  endfunction

  function automatic int rowOffset(int t, logic [31:0] prodMask, logic [31:0] sgnMask, int mw);
    int acc;
    acc = 0;
    for (int k = 0; k < t; k++) acc += rowsOfTerm(prodMask[k], sgnMask[k], mw);
    return acc;
  endfunction

  function automatic int negRows(int nTerm, logic [31:0] prodMask, logic [31:0] sgnMask,
                                 logic [31:0] subMask, int mw);
    int acc;
    acc = 0;
    for (int k = 0; k < nTerm; k++)
      if (subMask[k]) acc += rowsOfTerm(prodMask[k], sgnMask[k], mw);
    return acc;
  endfunction

  function automatic int stepRows(int n);
    return (n <= 2) ? n : (n / 3) * 2 + (n % 3);
  endfunction

  function automatic int rowsAtLevel(int n, int lvl);
    int m;
    m = n;
    for (int l = 0; l < lvl; l++) m = stepRows(m);
    return m;
  endfunction

  function automatic int levelCount(int n);
    int m;
    int l;
    m = n;
    l = 0;
    while (m > 2) begin
      m = stepRows(m);
      l++;
    end
    return l;
  endfunction

  function automatic int slotsBefore(int n, int lvl);
    int acc;
    acc = 0;
    for (int l = 0; l < lvl; l++) acc += rowsAtLevel(n, l) / 3;
    return acc;
  endfunction

  function automatic int spareRows(int base, int nCin);
    int e;
    e = 0;
    while (nCin - e > base + e - 2) e++;
    return e;
  endfunction

endpackage

// File: rtl/csa_macc_ctl.sv
module csa_macc_ctl
  import csa_macc_pkg::*;
#(
  parameter int W = 16,
  parameter int NTERM = 3,
  parameter int MW = 6,
  parameter logic [NTERM-1:0] PROD_MASK = '1,
  parameter logic [NTERM-1:0] SIGNED_MASK = '0,
  parameter logic [NTERM-1:0] SUB_MASK = '0
) (
  output termCtlT [NTERM-1:0] termCtl,
  output logic [W-1:0] injectOnes
);
  localparam int NNEG = negRows(NTERM, 32'(PROD_MASK), 32'(SIGNED_MASK), 32'(SUB_MASK), MW);

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    assign termCtl[t].negate = SUB_MASK[t];
    assign termCtl[t].signedOp = SIGNED_MASK[t];
  end

  // one +1 per inverted row completes each two's-complement negation
  assign injectOnes = W'(NNEG);
endmodule

// File: rtl/csa_macc_rowgen.sv
module csa_macc_rowgen
  import csa_macc_pkg::*;
#(
  parameter int W = 16,
  parameter int AW = 8,
  parameter int BW = 6,
  parameter bit PRODUCT = 1'b1,
  parameter bit SIGNED = 1'b0,
  localparam int MW = (BW <= AW) ? BW : AW,
  localparam int NW = (BW <= AW) ? AW : BW,
  localparam int NR = rowsOfTerm(PRODUCT, SIGNED, MW)
) (
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  input  termCtlT ctl,
  output logic [NR-1:0][W-1:0] rows
);
  logic [W-1:0] flipMask;
  assign flipMask = {W{ctl.negate}};

  if (PRODUCT) begin : g_prod
    logic [NW-1:0] mcand;
    logic [MW-1:0] mplier;
    logic [W-1:0] mcandExt;

    // the narrower operand drives the row count
    if (BW <= AW) begin : g_bmul
      assign mcand = a;
      assign mplier = b;
    end else begin : g_amul
      assign mcand = b;
      assign mplier = a;
    end

    for (genvar k = 0; k < W; k++) begin : g_ext
      if (k < NW) begin : g_in
        assign mcandExt[k] = mcand[k];
      end else begin : g_top
        assign mcandExt[k] = ctl.signedOp & mcand[NW-1];
      end
    end

    for (genvar i = 0; i < MW; i++) begin : g_row
      logic [W-1:0] shifted;
      assign shifted = mcandExt << i;
      if (SIGNED && i == MW - 1) begin : g_sign
        // negative-weight row: inverted upper part plus the sign bit at its column
        assign rows[i]  = ({W{mplier[i]}} & ~shifted & ({W{1'b1}} << i)) ^ flipMask;
        assign rows[MW] = ({{(W-1){1'b0}}, mplier[i]} << i) ^ flipMask;
      end else begin : g_plain
        assign rows[i] = ({W{mplier[i]}} & shifted) ^ flipMask;
      end
    end
  end else begin : g_add
    logic [W-1:0] aExt;
    logic unusedB;
    assign unusedB = ^b;
    for (genvar k = 0; k < W; k++) begin : g_ext
      if (k < AW) begin : g_in
        assign aExt[k] = a[k];
      end else begin : g_top
        assign aExt[k] = ctl.signedOp & a[AW-1];
      end
    end
    assign rows[0] = aExt ^ flipMask;
  end
endmodule

// File: rtl/csa_macc_tree.sv
module csa_macc_tree
  import csa_macc_pkg::*;
#(
  parameter int W = 16,
  parameter int NROWS = 15,
  parameter int NCIN = 2,
  localparam int NEXTRA = spareRows(NROWS, NCIN),
  localparam int NTOT = NROWS + NEXTRA,
  localparam int NLEV = levelCount(NTOT),
  localparam int NSLOT = NCIN - NEXTRA,
  localparam int NFIN = rowsAtLevel(NTOT, NLEV)
) (
  input  logic [NROWS-1:0][W-1:0] rowsIn,
  input  logic [NCIN-1:0] cinBits,
  output logic [W-1:0] sumRow,
  output logic [W-1:0] carryRow
);
  logic [NLEV:0][NTOT-1:0][W-1:0] lvl;
  logic unusedLvl;
  assign unusedLvl = ^lvl;

  for (genvar i = 0; i < NROWS; i++) begin : g_in
    assign lvl[0][i] = rowsIn[i];
  end
  // loose bits with no free slot become rows of their own
  for (genvar e = 0; e < NEXTRA; e++) begin : g_spare
    assign lvl[0][NROWS+e] = {{(W-1){1'b0}}, cinBits[NSLOT+e]};
  end

  for (genvar L = 0; L < NLEV; L++) begin : g_lvl
    localparam int N = rowsAtLevel(NTOT, L);
    localparam int G = N / 3;
    localparam int R = N % 3;
    localparam int SB = slotsBefore(NTOT, L);

    for (genvar g = 0; g < NTOT / 3; g++) begin : g_fa
      if (g < G) begin : g_on
        logic [W-1:0] x, y, z, half, sumBits, carryBits;
        logic lsb;
        assign x = lvl[L][3*g];
        assign y = lvl[L][3*g+1];
        assign z = lvl[L][3*g+2];
        assign half = x ^ y;
        assign sumBits = half ^ z;
        assign carryBits = (x & y) | (z & half);
        if (SB + g < NSLOT) begin : g_slot
          assign lsb = cinBits[SB+g];
        end else begin : g_noslot
          assign lsb = 1'b0;
        end
        assign lvl[L+1][2*g]   = sumBits;
        assign lvl[L+1][2*g+1] = {carryBits[W-2:0], lsb};
      end
    end

    for (genvar r = 0; r < 3; r++) begin : g_pass
      if (r < R) begin : g_on
        assign lvl[L+1][2*G+r] = lvl[L][3*G+r];
      end
    end

    for (genvar idx = 0; idx < NTOT; idx++) begin : g_fill
      if (idx >= 2*G + R) begin : g_on
        assign lvl[L+1][idx] = '0;
      end
    end
  end

  assign sumRow = lvl[NLEV][0];
  if (NFIN == 2) begin : g_two
    assign carryRow = lvl[NLEV][1];
  end else begin : g_one
    assign carryRow = '0;
  end
endmodule

// File: rtl/csa_macc.sv
module csa_macc
  import csa_macc_pkg::*;
#(
  parameter int W = 16,
  parameter int NTERM = 3,
  parameter int AW = 8,
  parameter int BW = 6,
  parameter int NCIN = 2,
  parameter logic [NTERM-1:0] PROD_MASK = 3'b011,
  parameter logic [NTERM-1:0] SIGNED_MASK = 3'b101,
  parameter logic [NTERM-1:0] SUB_MASK = 3'b110
) (
  input  logic [NTERM*AW-1:0] opA,
  input  logic [NTERM*BW-1:0] opB,
  input  logic [NCIN-1:0] carryBits,
  output logic [W-1:0] result
);
  localparam int MW = (BW <= AW) ? BW : AW;
  localparam int NTROWS = rowOffset(NTERM, 32'(PROD_MASK), 32'(SIGNED_MASK), MW);
  localparam int NROWS = NTROWS + 1;

  termCtlT [NTERM-1:0] termCtl;
  logic [W-1:0] injectOnes;
  logic [NROWS-1:0][W-1:0] allRows;
  logic [W-1:0] sumRow, carryRow, rawSum;

  csa_macc_ctl #(
    .W(W), .NTERM(NTERM), .MW(MW),
    .PROD_MASK(PROD_MASK), .SIGNED_MASK(SIGNED_MASK), .SUB_MASK(SUB_MASK)
  ) u_ctl (
    .termCtl(termCtl),
    .injectOnes(injectOnes)
  );

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    localparam int OFF = rowOffset(t, 32'(PROD_MASK), 32'(SIGNED_MASK), MW);
    localparam int NR = rowsOfTerm(PROD_MASK[t], SIGNED_MASK[t], MW);
    csa_macc_rowgen #(
      .W(W), .AW(AW), .BW(BW), .PRODUCT(PROD_MASK[t]), .SIGNED(SIGNED_MASK[t])
    ) u_rows (
      .a(opA[t*AW +: AW]),
      .b(opB[t*BW +: BW]),
      .ctl(termCtl[t]),
      .rows(allRows[OFF +: NR])
    );
  end

  assign allRows[NROWS-1] = injectOnes;

  csa_macc_tree #(.W(W), .NROWS(NROWS), .NCIN(NCIN)) u_tree (
    .rowsIn(allRows),
    .cinBits(carryBits),
    .sumRow(sumRow),
    .carryRow(carryRow)
  );

  assign rawSum = sumRow + carryRow;
  assign result = $isunknown({opA, opB, carryBits}) ? {W{1'bx}} : rawSum;
endmodule

// File: rtl/csa_macc_check.sv
module csa_macc_check #(
  parameter int W = 16,
  parameter int NTERM = 3,
  parameter int AW = 8,
  parameter int BW = 6,
  parameter int NCIN = 2,
  parameter int NROWS = 15,
  parameter logic [NTERM-1:0] PROD_MASK = '0,
  parameter logic [NTERM-1:0] SIGNED_MASK = '0,
  parameter logic [NTERM-1:0] SUB_MASK = '0
) (
  input logic [NTERM*AW-1:0] opA,
  input logic [NTERM*BW-1:0] opB,
  input logic [NCIN-1:0] carryBits,
  input logic [W-1:0] result,
  input logic [NROWS-1:0][W-1:0] allRows,
  input logic [W-1:0] sumRow,
  input logic [W-1:0] carryRow
);
  logic [W-1:0] refSum, rowTotal, looseTotal;
  logic known;

  always_comb begin
    looseTotal = '0;
    for (int c = 0; c < NCIN; c++) looseTotal += W'(carryBits[c]);
    refSum = looseTotal;
    for (int t = 0; t < NTERM; t++) begin
      logic [W-1:0] va, vb, term;
      for (int k = 0; k < W; k++) begin
        va[k] = (k < AW) ? opA[t*AW + ((k < AW) ? k : AW-1)] : (SIGNED_MASK[t] & opA[t*AW + AW-1]);
        vb[k] = (k < BW) ? opB[t*BW + ((k < BW) ? k : BW-1)] : (SIGNED_MASK[t] & opB[t*BW + BW-1]);
      end
      term = PROD_MASK[t] ? W'(va * vb) : va;
      refSum = SUB_MASK[t] ? refSum - term : refSum + term;
    end
    rowTotal = looseTotal;
    for (int i = 0; i < NROWS; i++) rowTotal += allRows[i];
    known = !$isunknown({opA, opB, carryBits});
  end

  always_comb begin
    if (known) begin
      a_r1_wrapped_sum: assert (result == refSum)
        else $error("R1 result %h expected %h", result, refSum);
      a_r3_rows_match_terms: assert (rowTotal == refSum)
        else $error("R3 row total %h expected %h", rowTotal, refSum);
      a_r6_tree_keeps_sum: assert (W'(sumRow + carryRow) == rowTotal)
        else $error("R6 tree output %h expected %h", W'(sumRow + carryRow), rowTotal);
      a_r7_zero_in_zero_out: assert (!(opA == '0 && opB == '0 && carryBits == '0) || result == '0)
        else $error("R7 result %h for all-zero inputs", result);
    end
  end
endmodule

bind csa_macc csa_macc_check #(
  .W(W), .NTERM(NTERM), .AW(AW), .BW(BW), .NCIN(NCIN), .NROWS(NROWS),
  .PROD_MASK(PROD_MASK), .SIGNED_MASK(SIGNED_MASK), .SUB_MASK(SUB_MASK)
) u_check (
  .opA(opA),
  .opB(opB),
  .carryBits(carryBits),
  .result(result),
  .allRows(allRows),
  .sumRow(sumRow),
  .carryRow(carryRow)
);

// File: tb/csa_macc_test.sv
`timescale 1ns/1ps
module csa_macc_test;
  localparam logic [2:0] PROD = 3'b011;
  localparam logic [2:0] SGN  = 3'b101;
  localparam logic [2:0] SUB0 = 3'b110;
  localparam logic [2:0] SUB1 = 3'b001;

  typedef struct {
    logic [15:0] e0;
    logic [15:0] e1;
    string req;
  } expT;

  logic clk = 1'b0;
  logic [23:0] opA = '0;
  logic [17:0] opB = '0;
  logic [1:0] cin = '0;
  logic [15:0] res0, res1;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  expT sbq[$];

  always #2 clk = ~clk;

  csa_macc #(.PROD_MASK(PROD), .SIGNED_MASK(SGN), .SUB_MASK(SUB0)) uut (
    .opA(opA), .opB(opB), .carryBits(cin), .result(res0));
  csa_macc #(.PROD_MASK(PROD), .SIGNED_MASK(SGN), .SUB_MASK(SUB1)) uutAlt (
    .opA(opA), .opB(opB), .carryBits(cin), .result(res1));

  function automatic logic [15:0] model(logic [23:0] a, logic [17:0] b, logic [1:0] c, logic [2:0] sub);
    longint acc;
    acc = longint'(c[0]) + longint'(c[1]);
    for (int t = 0; t < 3; t++) begin
      logic [7:0] fa;
      logic [5:0] fb;
      longint va, vb, term;
      fa = a[t*8 +: 8];
      fb = b[t*6 +: 6];
      va = SGN[t] ? longint'($signed(fa)) : longint'(fa);
      vb = SGN[t] ? longint'($signed(fb)) : longint'(fb);
      term = PROD[t] ? va * vb : va;
      acc = sub[t] ? acc - term : acc + term;
    end
    return acc[15:0];
  endfunction

  task automatic apply(input logic [23:0] a, input logic [17:0] b, input logic [1:0] c, input string req);
    expT item;
    @(posedge clk);
    #1;
    opA = a;
    opB = b;
    cin = c;
    item.e0 = model(a, b, c, SUB0);
    item.e1 = model(a, b, c, SUB1);
    item.req = req;
    sbq.push_back(item);
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      expT item;
      item = sbq.pop_front();
      nChecks += 2;
      if (res0 !== item.e0) begin
        nFails++;
        $display("FAIL %s uut: got %h expected %h", item.req, res0, item.e0);
      end
      if (res1 !== item.e1) begin
        nFails++;
        $display("FAIL %s uutAlt: got %h expected %h", item.req, res1, item.e1);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R7: idle state, every input zero
    apply('0, '0, 2'b00, "R7 all zero");
    // R2: signed term 0 at most negative A, times +1; signed addend at 0x80
    apply({8'h00, 8'h00, 8'h80}, {6'd0, 6'd0, 6'd1}, 2'b00, "R2 signed min times one");
    apply({8'h80, 8'h00, 8'h00}, '0, 2'b00, "R2 signed addend min");
    // R2: unsigned term 1 all ones in both fields
    apply({8'h00, 8'hFF, 8'h00}, {6'd0, 6'h3F, 6'd0}, 2'b00, "R2 unsigned all ones");
    // R3: signed product of both most negative values, -128 * -32
    apply({8'h00, 8'h00, 8'h80}, {6'd0, 6'd0, 6'h20}, 2'b00, "R3 min times min");
    apply({8'h00, 8'h00, 8'hFF}, {6'd0, 6'd0, 6'h3F}, 2'b00, "R3 minus one squared");
    apply({8'h00, 8'h00, 8'h7F}, {6'd0, 6'd0, 6'h1F}, 2'b00, "R3 max times max");
    // R4: only subtracted terms nonzero, then a zero subtracted term
    apply({8'h05, 8'h03, 8'h00}, {6'd0, 6'd7, 6'd0}, 2'b00, "R4 subtract only");
    apply({8'h00, 8'h00, 8'h11}, {6'd0, 6'd0, 6'd3}, 2'b00, "R4 zero subtrahend");
    // R5: addend term 2 with two different B fields
    apply({8'h2A, 8'h00, 8'h00}, {6'h00, 6'd0, 6'd0}, 2'b00, "R5 addend B clear");
    apply({8'h2A, 8'h00, 8'h00}, {6'h3F, 6'd0, 6'd0}, 2'b00, "R5 addend B set");
    // R6: every loose-bit pattern on zero terms
    apply('0, '0, 2'b01, "R6 loose bit 0");
    apply('0, '0, 2'b10, "R6 loose bit 1");
    apply('0, '0, 2'b11, "R6 both loose bits");
    // R8: negative totals wrap to their two's-complement code
    apply({8'h00, 8'hFF, 8'h00}, {6'd0, 6'h3F, 6'd0}, 2'b11, "R8 wrap negative");
    apply('1, '1, 2'b11, "R8 all ones everywhere");
    // R1: random operands across the whole tree
    for (int n = 0; n < 200; n++)
      apply(24'($urandom()), 18'($urandom()), 2'($urandom()), "R1 random");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule